// File: doc/BRIEF.md
# Ethernet Transmit Deferral and Error-Status Controller

This block decides when an Ethernet MAC may start a transmission, and it produces the two per-frame error flags tied to the medium: lost carrier and a missing collision-test (SQE) pulse. It watches carrier sense, the collision input, the MAC's own transmit activity, the selected physical port and the link-fail flag. From these it runs an interframe gap counter and raises a transmit-permit signal for as long as a pending request may go out.

In half duplex the medium counts as busy while the MAC transmits or carrier is present. The gap is timed from the end of both. Carrier that trails the MAC's own transmission is masked for a short blinding window. In full duplex only the local transmitter occupies the medium, so receive carrier and collisions have no effect. The gap is timed from the end of the local transmission. The status flags are masked according to the selected port, except that a 10BASE-T frame sent during link fail is always flagged.

Port code on `port_sel_i`: 0 = 10BASE-T, 1 = AUI, 2 = MII. Code 3 behaves like MII.

Top module: `eth_defer_ctrl`

## Requirements
- R1: After reset the gap counter is empty, so a held request sees `tx_permit_o` high at once when the medium is idle. `lost_carrier_o` and `sqe_err_o` are low.
- R2: With no carrier, `tx_permit_o` rises exactly IPG_CYCLES clock edges (default 24) after `tx_act_i` falls, in either duplex mode, with `tx_req_i` held high throughout.
- R3: In half duplex, unmasked carrier holds `tx_permit_o` low. The gap restarts from its full length and runs only once both transmit activity and carrier have ended.
- R4: In half duplex, carrier is ignored for deferral during the blinding window. The window covers the cycle in which `tx_act_i` falls and runs until clock edge BLIND_CYCLES+1 after that fall (default 10, that is 4 µs of nibble clocks at 10 Mb/s). Carrier that ends by that edge adds no delay. Carrier still present after it delays the permit to IPG_CYCLES edges after the carrier ends.
- R5: In full duplex, carrier sense has no effect on deferral. A request is granted during receive, and the gap is timed from the end of local transmit only.
- R6: `tx_permit_o` is low while `tx_act_i` is high and while `tx_req_i` is low.
- R7: `lost_carrier_o` is a one-cycle pulse on the first clock edge after `tx_act_i` falls. In half duplex it fires when carrier was never sampled high during the transmission.
- R8: In full duplex, lost-carrier reporting is masked for AUI and MII. With 10BASE-T selected, a link fail sampled during the transmission flags lost carrier in either duplex mode.
- R9: In half duplex with AUI selected, `sqe_err_o` pulses for one cycle on clock edge SQE_WIN+1 after `tx_act_i` falls (default 6). It fires unless the collision input was high on one of edges 2 to SQE_WIN+1. 10BASE-T and MII without link fail never flag it.
- R10: In full duplex the collision input is ignored and the SQE check is off, so AUI never flags. With 10BASE-T selected, a link fail during the transmission flags `sqe_err_o` at the same edge in either duplex mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Nibble-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| crs_i | input | 1 | Carrier sense from the PHY |
| col_i | input | 1 | Collision / SQE indication from the PHY |
| tx_act_i | input | 1 | MAC is currently transmitting |
| tx_req_i | input | 1 | MAC has a frame waiting to start |
| port_sel_i | input | 2 | Active port: 0 10BASE-T, 1 AUI, 2 MII |
| link_fail_i | input | 1 | 10BASE-T link is in fail state |
| full_dup_i | input | 1 | Full-duplex operation |
| tx_permit_o | output | 1 | Pending request may begin transmitting |
| lost_carrier_o | output | 1 | One-cycle lost-carrier flag |
| sqe_err_o | output | 1 | One-cycle missing-SQE flag |

## Verification
The checker checks the following properties on every cycle:
- A permit never appears inside the gap after a transmission.
- A permit never appears while carrier is unmasked in half duplex.
- A permit never appears during a transmission.
- Both status outputs are single-cycle pulses.
- Lost carrier and SQE errors are never flagged for a masked port in full duplex.

Only the bench's scenarios can show several other points:
- The exact permit edge for each carrier timing around the blinding boundary.
- That full duplex grants during receive.
- That the status pulses appear on the right edge with the right value for each combination of duplex, port, link state, carrier and collision.

// File: rtl/eth_defer_pkg.sv
// Shared types for the transmit deferral controller.
// Assumes a two-bit port code where 0, 1 and 2 select the three media ports.
package eth_defer_pkg;
    typedef enum logic [1:0] {
        PORT_TP   = 2'd0,
        PORT_AUI  = 2'd1,
        PORT_MII  = 2'd2,
        PORT_RSVD = 2'd3
    } media_port_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TX   = 2'd1,
        ST_SQE  = 2'd2
    } stat_state_e;
endpackage

// File: rtl/edc_blind_timer.sv
// Carrier blinding window after the MAC's own transmission (half duplex only).
// Assumes tx_act_i is synchronous to clk. The window covers the cycle in which
// tx_act_i falls plus BLIND_CYCLES further cycles.
module edc_blind_timer #(
    parameter int BLIND_CYCLES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_act_i,
    input  logic full_dup_i,
    output logic blind_o
);
    localparam int BW = $clog2(BLIND_CYCLES + 1);

    logic          tx_q;
    logic [BW-1:0] cnt;

    // Load the window on the falling edge of transmit activity, then count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= 1'b0;
            cnt  <= '0;
        end else begin
            tx_q <= tx_act_i;
            if (tx_q && !tx_act_i) begin
                cnt <= BW'(BLIND_CYCLES);
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // Blinding applies only in half duplex.
    always_comb begin
        blind_o = !full_dup_i && (tx_q || (cnt != '0));
    end
endmodule

// File: rtl/edc_ipg_timer.sv
// Interframe gap counter: held at full length while the medium is busy,
// counts down once it is idle, and reports the gap open when empty.
// Assumes the caller folds the duplex-dependent busy definition into busy_i.
module edc_ipg_timer #(
    parameter int IPG_CYCLES = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    output logic gap_open_o
);
    localparam int GW = $clog2(IPG_CYCLES + 1);

    logic [GW-1:0] cnt;

    // Reload on busy, count down when idle, rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (busy_i) begin
            cnt <= GW'(IPG_CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Gap is open once the counter is empty and nothing holds the medium.
    always_comb begin
        gap_open_o = !busy_i && (cnt == '0);
    end
endmodule

// File: rtl/edc_status_unit.sv
// Per-frame status: lost carrier at transmit end, missing SQE pulse after a
// listening window. Masks follow duplex mode and selected port.
// Assumes SQE_WIN >= 1 and that a new transmission does not begin inside the
// listening window (the gap counter guarantees this when SQE_WIN < IPG).
module edc_status_unit
    import eth_defer_pkg::*;
#(
    parameter int SQE_WIN = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_act_i,
    input  logic        crs_i,
    input  logic        col_i,
    input  logic        link_fail_i,
    input  logic        full_dup_i,
    input  media_port_e port_i,
    output logic        lost_carrier_o,
    output logic        sqe_err_o
);
    localparam int WW = (SQE_WIN > 1) ? $clog2(SQE_WIN) : 1;

    stat_state_e   state;
    logic [WW-1:0] wcnt;
    logic          carrier_seen;
    logic          lf_seen;
    logic          col_seen;
    logic          col_eff;
    logic          tp_fail;
    logic          lcar_cond;
    logic          sqe_cond;

    // Collision is ignored in full duplex; error conditions per duplex and port.
    always_comb begin
        col_eff   = col_i && !full_dup_i;
        tp_fail   = (port_i == PORT_TP) && lf_seen;
        lcar_cond = tp_fail || (!full_dup_i && !carrier_seen);
        sqe_cond  = tp_fail || (!full_dup_i && (port_i == PORT_AUI)
                                && !(col_seen || col_eff));
    end

    // Frame tracker: capture carrier and link state in transmit, then listen for SQE.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state          <= ST_IDLE;
            wcnt           <= '0;
            carrier_seen   <= 1'b0;
            lf_seen        <= 1'b0;
            col_seen       <= 1'b0;
            lost_carrier_o <= 1'b0;
            sqe_err_o      <= 1'b0;
        end else begin
            lost_carrier_o <= 1'b0;
            sqe_err_o      <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (tx_act_i) begin
                        state        <= ST_TX;
                        carrier_seen <= crs_i;
                        lf_seen      <= link_fail_i;
                    end
                end
                ST_TX: begin
                    if (tx_act_i) begin
                        carrier_seen <= carrier_seen | crs_i;
                        lf_seen      <= lf_seen | link_fail_i;
                    end else begin
                        lost_carrier_o <= lcar_cond;
                        state          <= ST_SQE;
                        wcnt           <= WW'(SQE_WIN - 1);
                        col_seen       <= 1'b0;
                    end
                end
                ST_SQE: begin
                    if (tx_act_i) begin
                        state        <= ST_TX;
                        carrier_seen <= crs_i;
                        lf_seen      <= link_fail_i;
                    end else if (wcnt == '0) begin
                        sqe_err_o <= sqe_cond;
                        state     <= ST_IDLE;
                    end else begin
                        wcnt     <= wcnt - 1'b1;
                        col_seen <= col_seen | col_eff;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/eth_defer_ctrl.sv
// Top of the transmit deferral controller. Combines the blinding window,
// the interframe gap counter and the status unit. Half duplex treats own
// transmit plus unmasked carrier as busy; full duplex treats only own transmit
// as busy.
// Assumes all inputs are synchronous to clk and BLIND_CYCLES + 1 < IPG_CYCLES.
module eth_defer_ctrl
    import eth_defer_pkg::*;
#(
    parameter int IPG_CYCLES   = 24,
    parameter int BLIND_CYCLES = 10,
    parameter int SQE_WIN      = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       crs_i,
    input  logic       col_i,
    input  logic       tx_act_i,
    input  logic       tx_req_i,
    input  logic [1:0] port_sel_i,
    input  logic       link_fail_i,
    input  logic       full_dup_i,
    output logic       tx_permit_o,
    output logic       lost_carrier_o,
    output logic       sqe_err_o
);
    logic        blind;
    logic        carrier_eff;
    logic        busy;
    logic        gap_open;
    media_port_e port;

    // Decode the port code and form the busy condition for the gap counter.
    always_comb begin
        port        = media_port_e'(port_sel_i);
        carrier_eff = crs_i && !full_dup_i && !blind;
        busy        = tx_act_i || carrier_eff;
        tx_permit_o = tx_req_i && gap_open;
    end

    edc_blind_timer #(.BLIND_CYCLES(BLIND_CYCLES)) u_blind (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_act_i   (tx_act_i),
        .full_dup_i (full_dup_i),
        .blind_o    (blind)
    );

    edc_ipg_timer #(.IPG_CYCLES(IPG_CYCLES)) u_ipg (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_i     (busy),
        .gap_open_o (gap_open)
    );

    edc_status_unit #(.SQE_WIN(SQE_WIN)) u_stat (
        .clk            (clk),
        .rst_n          (rst_n),
        .tx_act_i       (tx_act_i),
        .crs_i          (crs_i),
        .col_i          (col_i),
        .link_fail_i    (link_fail_i),
        .full_dup_i     (full_dup_i),
        .port_i         (port),
        .lost_carrier_o (lost_carrier_o),
        .sqe_err_o      (sqe_err_o)
    );
endmodule

// File: rtl/edc_checker.sv
// Assertion checker for eth_defer_ctrl, bound to every instance.
// Keeps its own count of idle cycles since transmit ended.
module edc_checker #(
    parameter int IPG_CYCLES   = 24,
    parameter int BLIND_CYCLES = 10
) (
    input logic       clk,
    input logic       rst_n,
    input logic       crs_i,
    input logic       tx_act_i,
    input logic       tx_req_i,
    input logic [1:0] port_sel_i,
    input logic       full_dup_i,
    input logic       tx_permit_o,
    input logic       lost_carrier_o,
    input logic       sqe_err_o
);
    localparam int SAT = IPG_CYCLES + BLIND_CYCLES + 1;
    localparam int SW  = $clog2(SAT + 1);

    logic [SW-1:0] since_tx;

    // Idle cycles since transmit ended, saturating; starts saturated after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_tx <= SW'(SAT);
        end else if (tx_act_i) begin
            since_tx <= '0;
        end else if (since_tx != SW'(SAT)) begin
            since_tx <= since_tx + 1'b1;
        end
    end

    AST_GAP_AFTER_TX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_permit_o |-> (since_tx >= SW'(IPG_CYCLES))); // R2
    AST_HD_CARRIER_DEFERS: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_dup_i && crs_i && since_tx > SW'(BLIND_CYCLES)) |-> !tx_permit_o); // R3
    AST_NO_PERMIT_IN_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_act_i || !tx_req_i) |-> !tx_permit_o); // R6
    AST_LCAR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        lost_carrier_o |=> !lost_carrier_o); // R7
    AST_LCAR_FD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        lost_carrier_o |-> (!$past(full_dup_i) || $past(port_sel_i) == 2'd0)); // R8
    AST_SQE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sqe_err_o |=> !sqe_err_o); // R9
    AST_SQE_FD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        sqe_err_o |-> (!$past(full_dup_i) || $past(port_sel_i) == 2'd0)); // R10
endmodule

bind eth_defer_ctrl edc_checker #(
    .IPG_CYCLES   (IPG_CYCLES),
    .BLIND_CYCLES (BLIND_CYCLES)
) u_edc_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .crs_i          (crs_i),
    .tx_act_i       (tx_act_i),
    .tx_req_i       (tx_req_i),
    .port_sel_i     (port_sel_i),
    .full_dup_i     (full_dup_i),
    .tx_permit_o    (tx_permit_o),
    .lost_carrier_o (lost_carrier_o),
    .sqe_err_o      (sqe_err_o)
);

// File: tb/eth_defer_ctrl_bench.sv
// Self-checking bench: sweeps duplex, port, link, carrier and collision per
// frame, plus carrier timing around the blinding boundary.
module eth_defer_ctrl_bench;
    localparam int IPG   = 24;
    localparam int BLIND = 10;
    localparam int SQW   = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       crs_i = 1'b0;
    logic       col_i = 1'b0;
    logic       tx_act_i = 1'b0;
    logic       tx_req_i = 1'b0;
    logic [1:0] port_sel_i = 2'd0;
    logic       link_fail_i = 1'b0;
    logic       full_dup_i = 1'b0;
    logic       tx_permit_o;
    logic       lost_carrier_o;
    logic       sqe_err_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    eth_defer_ctrl #(.IPG_CYCLES(IPG), .BLIND_CYCLES(BLIND), .SQE_WIN(SQW)) u_eth_defer_ctrl (
        .clk(clk), .rst_n(rst_n), .crs_i(crs_i), .col_i(col_i),
        .tx_act_i(tx_act_i), .tx_req_i(tx_req_i), .port_sel_i(port_sel_i),
        .link_fail_i(link_fail_i), .full_dup_i(full_dup_i),
        .tx_permit_o(tx_permit_o), .lost_carrier_o(lost_carrier_o),
        .sqe_err_o(sqe_err_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // One frame through the sweep: checks R6 in transmit, R7..R10 after it, R2 gap.
    task automatic frame(input logic fd, input logic [1:0] prt, input logic lf,
                         input logic crs_tx, input logic col_win);
        logic exp_lcar;
        logic exp_sqe;
        exp_lcar = (prt == 2'd0 && lf) || (!fd && !crs_tx);
        exp_sqe  = (prt == 2'd0 && lf) || (!fd && prt == 2'd1 && !col_win);
        @(negedge clk);
        full_dup_i = fd; port_sel_i = prt; link_fail_i = lf;
        crs_i = crs_tx; tx_act_i = 1'b1; tx_req_i = 1'b1;
        repeat (5) tick();
        check("R6 permit during transmit", tx_permit_o, 1'b0);
        @(negedge clk);
        tx_act_i = 1'b0; crs_i = 1'b0; col_i = col_win;
        for (int e = 1; e <= IPG; e++) begin
            tick();
            if (e == 1) check("R7/R8 lost carrier at end", lost_carrier_o, exp_lcar);
            if (e == 2) check("R7 lost carrier single pulse", lost_carrier_o, 1'b0);
            if (e == SQW) check("R9 sqe quiet inside window", sqe_err_o, 1'b0);
            if (e == SQW + 1) check("R9/R10 sqe at window end", sqe_err_o, exp_sqe);
            if (e == SQW + 2) check("R9 sqe single pulse", sqe_err_o, 1'b0);
            if (e == IPG - 1) check("R2 permit before gap end", tx_permit_o, 1'b0);
            if (e == IPG) check("R2 permit at gap end", tx_permit_o, 1'b1);
            if (e == SQW + 1) begin
                @(negedge clk);
                col_i = 1'b0;
            end
        end
        @(negedge clk);
        tx_req_i = 1'b0; link_fail_i = 1'b0;
    endtask

    // Transmit, then carrier held for 'hold' edges after the end (R4, R5).
    task automatic tx_then_crs(input logic fd, input int hold);
        int exp_e;
        if (fd || hold <= BLIND + 1) exp_e = IPG;
        else exp_e = hold + IPG;
        @(negedge clk);
        full_dup_i = fd; port_sel_i = 2'd2; crs_i = 1'b1; tx_act_i = 1'b1; tx_req_i = 1'b1;
        repeat (4) tick();
        @(negedge clk);
        tx_act_i = 1'b0;
        for (int e = 1; e <= exp_e; e++) begin
            tick();
            if (e == exp_e - 1) check(fd ? "R5 fd no carrier delay, early" : "R4 blinding, early",
                                      tx_permit_o, 1'b0);
            if (e == exp_e) check(fd ? "R5 fd no carrier delay" : "R4 blinding permit edge",
                                  tx_permit_o, 1'b1);
            if (e == hold) begin
                @(negedge clk);
                crs_i = 1'b0;
            end
        end
        @(negedge clk);
        crs_i = 1'b0; tx_req_i = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tx_req_i = 1'b1;
        tick();
        // R1: gap empty and flags clear after reset
        check("R1 permit after reset", tx_permit_o, 1'b1);
        check("R1 lost carrier after reset", lost_carrier_o, 1'b0);
        check("R1 sqe after reset", sqe_err_o, 1'b0);
        @(negedge clk);
        tx_req_i = 1'b0;
        tick();
        check("R6 no permit without request", tx_permit_o, 1'b0);

        // R3: remote carrier defers in half duplex, gap timed from carrier end
        @(negedge clk);
        full_dup_i = 1'b0; crs_i = 1'b1; tx_req_i = 1'b1;
        repeat (5) tick();
        check("R3 carrier holds off permit", tx_permit_o, 1'b0);
        @(negedge clk);
        crs_i = 1'b0;
        repeat (IPG - 1) tick();
        check("R3 gap from carrier end, early", tx_permit_o, 1'b0);
        tick();
        check("R3 gap from carrier end", tx_permit_o, 1'b1);
        // R5: full duplex grants while receiving
        @(negedge clk);
        full_dup_i = 1'b1; crs_i = 1'b1;
        tick();
        check("R5 fd permit during receive", tx_permit_o, 1'b1);
        @(negedge clk);
        crs_i = 1'b0; tx_req_i = 1'b0;

        for (int f = 0; f < 2; f++)
            for (int p = 0; p < 3; p++)
                for (int l = 0; l < 2; l++)
                    for (int c = 0; c < 2; c++)
                        for (int k = 0; k < 2; k++)
                            frame(f[0], p[1:0], l[0], c[0], k[0]);

        tx_then_crs(1'b0, 3);
        tx_then_crs(1'b0, BLIND + 1);
        tx_then_crs(1'b0, BLIND + 2);
        tx_then_crs(1'b0, BLIND + 6);
        tx_then_crs(1'b1, BLIND + 6);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule